// File: doc/BRIEF.md
# Debug Single-Step Trace Sequencer

This block sits inside a microcontroller debug engine and carries out one host single-step command while the CPU is held in debug mode. On a trace strobe it reports busy, takes the saved return address off the hardware stack, and puts back the interrupt global enable that was in force when debug mode was entered. It then releases the CPU to fetch and execute exactly one instruction from that address.

Once the CPU reports that instruction done, the block stalls the CPU and keeps the program-memory fetch path blocked. It pushes the CPU's current instruction pointer as the new return address and loads the instruction pointer with the debug vector. Last, it clears the interrupt enable, halts the CPU and reports idle again.

The host sees only a two-bit status. The CPU side sees a fetch request with its address and the stall, halt and fetch-block levels. The block also drives the instruction-pointer load and interrupt-enable write strobes and a single-cycle push/pop stack port.

Top module: `trace_step_seq`

## Requirements
- R1: After reset, status is 01 (idle), cpuHalt and fetchBlock are 1, and stkPop, stkPush, fetchReq, ipLoad, igeWrite and cpuStall are 0.
- R2: A traceCmd sampled while idle makes status 10 (busy) in the next cycle, and stkPop is high for exactly that one cycle.
- R3: One cycle after the pop, igeWrite pulses for one cycle. igeWriteVal equals the igeIn value sampled at the most recent dbgEnter pulse, or 0 if there has been no dbgEnter since reset.
- R4: One cycle after the interrupt-enable restore, fetchReq pulses for one cycle with fetchAddr equal to the stkPopData value sampled during the pop cycle, and cpuHalt is 0.
- R5: From the fetch request until instrDone, cpuHalt stays 0, fetchBlock is 1 and no further fetchReq occurs, so each command yields exactly one fetch.
- R6: The cycle after instrDone, cpuStall is 1. In the cycle after that, stkPush pulses with stkPushData equal to the cpuIp value sampled during the stall cycle.
- R7: The cycle after the push, ipLoad pulses with ipLoadVal equal to 0x8010.
- R8: The cycle after the instruction-pointer load, igeWrite pulses with igeWriteVal 0. In the following cycle status returns to 01 and cpuHalt is 1.
- R9: A traceCmd arriving while status is 10 is ignored: no pop follows once the sequence completes.
- R10: status only ever takes the values 01 and 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| traceCmd | input | 1 | Host single-step strobe |
| dbgEnter | input | 1 | Pulse when debug mode is entered |
| igeIn | input | 1 | CPU interrupt global enable, sampled on dbgEnter |
| status | output | 2 | 01 idle, 10 busy |
| stkPop | output | 1 | Stack pop strobe |
| stkPopData | input | 16 | Data from the stack top during a pop |
| stkPush | output | 1 | Stack push strobe |
| stkPushData | output | 16 | Return address to push |
| fetchReq | output | 1 | One-cycle request to fetch the stepped instruction |
| fetchAddr | output | 16 | Address of the stepped instruction |
| fetchBlock | output | 1 | Blocks program-memory fetches |
| instrDone | input | 1 | One-cycle pulse when the CPU finishes the instruction |
| cpuIp | input | 16 | CPU instruction pointer |
| cpuStall | output | 1 | Stalls the CPU after the step |
| cpuHalt | output | 1 | Holds the CPU halted |
| ipLoad | output | 1 | Instruction-pointer load strobe |
| ipLoadVal | output | 16 | Value loaded into the instruction pointer |
| igeWrite | output | 1 | Interrupt-enable write strobe |
| igeWriteVal | output | 1 | Value written to the interrupt enable |

## Verification
Each step uses a random popped address, a random post-step instruction pointer and a random number of cycles spent waiting for instrDone. A pass-through of the address can therefore be told apart from a stale or swapped value, and the push value from the pop value. The interrupt enable captured at entry is toggled randomly between steps, and some steps have no fresh dbgEnter, so a restore that reads the live input can be told apart from one that reads the held flag. Some steps also raise traceCmd repeatedly while busy, which shows whether a busy command starts a second sequence. A zero-wait step checks that the instrDone pulse arriving straight after the fetch is still seen.

// File: rtl/tss_pkg.sv
package tss_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_POP,
    ST_IGE,
    ST_LAUNCH,
    ST_EXEC,
    ST_STALL,
    ST_PUSH,
    ST_VEC,
    ST_CLRIGE
  } tssState_e;

  typedef struct packed {
    logic capRet;
    logic capIp;
    logic restoreIge;
  } tssStrobe_t;

  localparam logic [1:0] STAT_IDLE = 2'b01;
  localparam logic [1:0] STAT_BUSY = 2'b10;
endpackage

// File: rtl/tss_ctrl.sv
module tss_ctrl
  import tss_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       traceCmd,
  input  logic       instrDone,
  output tssStrobe_t strobe,
  output logic [1:0] status,
  output logic       stkPop,
  output logic       stkPush,
  output logic       fetchReq,
  output logic       fetchBlock,
  output logic       cpuStall,
  output logic       cpuHalt,
  output logic       ipLoad,
  output logic       igeWrite
);
  tssState_e state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:   if (traceCmd) stateNext = ST_POP;
      ST_POP:    stateNext = ST_IGE;
      ST_IGE:    stateNext = ST_LAUNCH;
      ST_LAUNCH: stateNext = instrDone ? ST_STALL : ST_EXEC;
      ST_EXEC:   if (instrDone) stateNext = ST_STALL;
      ST_STALL:  stateNext = ST_PUSH;
      ST_PUSH:   stateNext = ST_VEC;
      ST_VEC:    stateNext = ST_CLRIGE;
      ST_CLRIGE: stateNext = ST_IDLE;
      default:   stateNext = ST_IDLE;
    endcase
  end

  always_comb begin
    status            = (state == ST_IDLE) ? STAT_IDLE : STAT_BUSY;
    stkPop            = (state == ST_POP);
    stkPush           = (state == ST_PUSH);
    fetchReq          = (state == ST_LAUNCH);
    fetchBlock        = (state != ST_LAUNCH);
    cpuHalt           = !(state == ST_LAUNCH || state == ST_EXEC);
    cpuStall          = (state == ST_STALL) || (state == ST_PUSH) ||
                        (state == ST_VEC) || (state == ST_CLRIGE);
    ipLoad            = (state == ST_VEC);
    igeWrite          = (state == ST_IGE) || (state == ST_CLRIGE);
    strobe.capRet     = (state == ST_POP);
    strobe.capIp      = (state == ST_STALL);
    strobe.restoreIge = (state == ST_IGE);
  end

  // R2: an idle command produces a pop on the next cycle
  a_r2_pop_after_cmd: assert property (@(posedge clk) disable iff (!rstN)
    (status == STAT_IDLE && traceCmd) |=> (stkPop && status == STAT_BUSY));
  // R5: a fetch request never repeats back to back
  a_r5_single_fetch: assert property (@(posedge clk) disable iff (!rstN)
    fetchReq |=> !fetchReq);
  // R6: a push is always preceded by a stall cycle
  a_r6_push_after_stall: assert property (@(posedge clk) disable iff (!rstN)
    stkPush |-> $past(cpuStall));
  // R7: the vector load follows the push
  a_r7_load_after_push: assert property (@(posedge clk) disable iff (!rstN)
    stkPush |=> ipLoad);
  // R9: a command while busy does not restart the pop
  a_r9_busy_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (status == STAT_BUSY && traceCmd && !stkPush) |=> !stkPop);
  // R10: status is always a legal code
  a_r10_status_legal: assert property (@(posedge clk) disable iff (!rstN)
    (status == STAT_IDLE) || (status == STAT_BUSY));
endmodule

// File: rtl/tss_dp.sv
module tss_dp
  import tss_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] DBG_VEC = 'h8010
) (
  input  logic              clk,
  input  logic              rstN,
  input  tssStrobe_t        strobe,
  input  logic              dbgEnter,
  input  logic              igeIn,
  input  logic [ADDR_W-1:0] stkPopData,
  input  logic [ADDR_W-1:0] cpuIp,
  output logic [ADDR_W-1:0] stkPushData,
  output logic [ADDR_W-1:0] fetchAddr,
  output logic [ADDR_W-1:0] ipLoadVal,
  output logic              igeWriteVal
);
  logic [ADDR_W-1:0] retAddr;
  logic [ADDR_W-1:0] nextRet;
  logic              savedIge;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      retAddr  <= '0;
      nextRet  <= '0;
      savedIge <= 1'b0;
    end else begin
      if (strobe.capRet) retAddr  <= stkPopData;
      if (strobe.capIp)  nextRet  <= cpuIp;
      if (dbgEnter)      savedIge <= igeIn;
    end
  end

  assign fetchAddr   = retAddr;
  assign stkPushData = nextRet;
  assign ipLoadVal   = DBG_VEC;
  assign igeWriteVal = strobe.restoreIge ? savedIge : 1'b0;

  // R4: the fetch address is the value popped two cycles earlier
  a_r4_fetch_is_popped: assert property (@(posedge clk) disable iff (!rstN)
    $past(strobe.capRet, 2) |-> fetchAddr == $past(stkPopData, 2));
  // R6: the pushed value is the instruction pointer seen in the stall cycle
  a_r6_push_value: assert property (@(posedge clk) disable iff (!rstN)
    $past(strobe.capIp) |-> stkPushData == $past(cpuIp));
endmodule

// File: rtl/trace_step_seq.sv
module trace_step_seq
  import tss_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] DBG_VEC = 'h8010
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              traceCmd,
  input  logic              dbgEnter,
  input  logic              igeIn,
  output logic [1:0]        status,
  output logic              stkPop,
  input  logic [ADDR_W-1:0] stkPopData,
  output logic              stkPush,
  output logic [ADDR_W-1:0] stkPushData,
  output logic              fetchReq,
  output logic [ADDR_W-1:0] fetchAddr,
  output logic              fetchBlock,
  input  logic              instrDone,
  input  logic [ADDR_W-1:0] cpuIp,
  output logic              cpuStall,
  output logic              cpuHalt,
  output logic              ipLoad,
  output logic [ADDR_W-1:0] ipLoadVal,
  output logic              igeWrite,
  output logic              igeWriteVal
);
  tssStrobe_t strobe;

  tss_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .traceCmd(traceCmd), .instrDone(instrDone),
    .strobe(strobe), .status(status), .stkPop(stkPop), .stkPush(stkPush),
    .fetchReq(fetchReq), .fetchBlock(fetchBlock), .cpuStall(cpuStall),
    .cpuHalt(cpuHalt), .ipLoad(ipLoad), .igeWrite(igeWrite)
  );

  tss_dp #(.ADDR_W(ADDR_W), .DBG_VEC(DBG_VEC)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .dbgEnter(dbgEnter),
    .igeIn(igeIn), .stkPopData(stkPopData), .cpuIp(cpuIp),
    .stkPushData(stkPushData), .fetchAddr(fetchAddr),
    .ipLoadVal(ipLoadVal), .igeWriteVal(igeWriteVal)
  );

  // R8: an interrupt-enable write while stalled always writes zero
  a_r8_clear_ige: assert property (@(posedge clk) disable iff (!rstN)
    (igeWrite && cpuStall) |-> !igeWriteVal);
endmodule

// File: tb/trace_step_seq_bench.sv
module trace_step_seq_bench;
  logic        clk = 1'b0;
  logic        rstN;
  logic        traceCmd, dbgEnter, igeIn, instrDone;
  logic [15:0] stkPopData, cpuIp;
  logic [1:0]  status;
  logic        stkPop, stkPush, fetchReq, fetchBlock, cpuStall, cpuHalt;
  logic        ipLoad, igeWrite, igeWriteVal;
  logic [15:0] stkPushData, fetchAddr, ipLoadVal;

  int errors = 0;
  int checks = 0;
  logic expIge = 1'b0;

  always #10 clk = ~clk;

  trace_step_seq u_trace_step_seq (
    .clk(clk), .rstN(rstN), .traceCmd(traceCmd), .dbgEnter(dbgEnter),
    .igeIn(igeIn), .status(status), .stkPop(stkPop), .stkPopData(stkPopData),
    .stkPush(stkPush), .stkPushData(stkPushData), .fetchReq(fetchReq),
    .fetchAddr(fetchAddr), .fetchBlock(fetchBlock), .instrDone(instrDone),
    .cpuIp(cpuIp), .cpuStall(cpuStall), .cpuHalt(cpuHalt), .ipLoad(ipLoad),
    .ipLoadVal(ipLoadVal), .igeWrite(igeWrite), .igeWriteVal(igeWriteVal)
  );

  function automatic logic [15:0] expVector();
    return 16'h8010;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one full step; inputs change at negedge, outputs read at negedge
  task automatic doTrace(input logic [15:0] ret, input logic [15:0] ipAfter,
                         input int waitCycles, input bit spam);
    traceCmd = 1'b1;
    @(negedge clk);
    traceCmd = spam;
    stkPopData = ret;
    chk("R2 status busy", {30'd0, status}, 32'h2);
    chk("R2 pop", {31'd0, stkPop}, 1);
    @(negedge clk);
    chk("R2 pop one cycle", {31'd0, stkPop}, 0);
    chk("R3 ige write", {31'd0, igeWrite}, 1);
    chk("R3 ige value", {31'd0, igeWriteVal}, {31'd0, expIge});
    stkPopData = ~ret;
    @(negedge clk);
    chk("R4 fetch req", {31'd0, fetchReq}, 1);
    chk("R4 fetch addr", {16'd0, fetchAddr}, {16'd0, ret});
    chk("R4 halt low", {31'd0, cpuHalt}, 0);
    for (int i = 0; i < waitCycles; i++) begin
      @(negedge clk);
      chk("R5 no refetch", {31'd0, fetchReq}, 0);
      chk("R5 block and run", {30'd0, fetchBlock, cpuHalt}, 32'h2);
    end
    instrDone = 1'b1;
    @(negedge clk);
    instrDone = 1'b0;
    cpuIp = ipAfter;
    chk("R6 stall", {31'd0, cpuStall}, 1);
    chk("R6 no push yet", {31'd0, stkPush}, 0);
    @(negedge clk);
    cpuIp = ~ipAfter;
    chk("R6 push", {31'd0, stkPush}, 1);
    chk("R6 push data", {16'd0, stkPushData}, {16'd0, ipAfter});
    @(negedge clk);
    chk("R7 ip load", {31'd0, ipLoad}, 1);
    chk("R7 vector", {16'd0, ipLoadVal}, {16'd0, expVector()});
    @(negedge clk);
    chk("R8 ige clear", {30'd0, igeWrite, igeWriteVal}, 32'h2);
    traceCmd = 1'b0;
    @(negedge clk);
    chk("R8 idle", {30'd0, status}, 32'h1);
    chk("R8 halted", {31'd0, cpuHalt}, 1);
    if (spam) begin
      @(negedge clk);
      chk("R9 busy cmd ignored", {29'd0, stkPop, status}, 32'h1);
    end
  endtask

  initial begin
    #2000000;
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rstN = 1'b0; traceCmd = 1'b0; dbgEnter = 1'b0; igeIn = 1'b0;
    instrDone = 1'b0; stkPopData = '0; cpuIp = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 status", {30'd0, status}, 32'h1);
    chk("R1 halt block", {30'd0, cpuHalt, fetchBlock}, 32'h3);
    chk("R1 strobes", {26'd0, stkPop, stkPush, fetchReq, ipLoad, igeWrite, cpuStall}, 0);

    // directed: no dbgEnter yet, zero wait
    doTrace(16'h1234, 16'h1235, 0, 1'b0);
    // directed: enable captured as 1, then live input changed
    igeIn = 1'b1; dbgEnter = 1'b1; expIge = 1'b1;
    @(negedge clk);
    dbgEnter = 1'b0; igeIn = 1'b0;
    doTrace(16'hFFFF, 16'h0000, 3, 1'b1);

    for (int n = 0; n < 24; n++) begin
      if ($urandom_range(0, 1) == 1) begin
        logic v;
        v = 1'($urandom_range(0, 1));
        igeIn = v; dbgEnter = 1'b1; expIge = v;
        @(negedge clk);
        dbgEnter = 1'b0; igeIn = ~v;
      end
      doTrace(16'($urandom), 16'($urandom), $urandom_range(0, 6),
              1'($urandom_range(0, 1)));
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule